// File: doc/BRIEF.md
# Slot Power Sequencer

This block steps a removable card slot through its power-up and power-down sequences. It drives writes into an external 2-bit slot power-state field and reads the field's current value back. It releases the card's reset line once power is stable. A requester issues a single-cycle power-on or power-off command, watches `busy`, and gets a one-cycle `done` strobe with an error flag when the sequence ends.

Power-state codes are 0 = off, 1 = preparing, 2 = on, and 3 = switching off. The surrounding hardware moves code 3 to 0 by itself, and it also forces the field to 0 when the card is pulled out.

Before a command makes any decision, it lets any switch-off already in progress finish. A command that has nothing to do ends at once. Power-up has four timed waits, and each is a parameter given in clock cycles. Power-down asks for switch-off and then waits for the field to reach 0.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `pwr_wr_en` and `slot_rst_rel` are all 0.
- R2: An accepted command makes no decision while `pwr_rd` reads 3. The decision is taken at the first clock edge after a cycle in which `pwr_rd` is not 3. A command that finds 0 there proceeds by R4 or ends by R6.
- R3: A power-on command that finds `pwr_rd` other than 0 ends at its decision edge. It sets `done` with `err`=0 and writes nothing.
- R4: A power-on command that finds `pwr_rd`=0 writes code 1 exactly DLY_PREP cycles after its decision edge. It then writes code 2 exactly DLY_APPLY cycles later.
- R5: `slot_rst_rel` rises exactly DLY_RELEASE cycles after the code-2 write. `done` follows with `err`=0 exactly DLY_SETTLE cycles after that.
- R6: A power-off command that finds `pwr_rd` other than 2 ends at its decision edge, with `done` and `err`=0 and no write.
- R7: A power-off command that finds `pwr_rd`=2 writes code 3 at its decision edge and clears `slot_rst_rel` at that same edge. It raises `done` one cycle after the first cycle in which `pwr_rd` reads 0.
- R8: `busy` rises on the edge that accepts a command and falls on the edge that raises `done`. `done` is a one-cycle pulse, and `busy` is 0 while `done` is 1.
- R9: A command that arrives while `busy` is 1 is ignored. If `cmd_on` and `cmd_off` are both asserted while idle, power-on is taken.
- R10: If `card_present` is low during a power-on, the sequence ends on the next edge with `done`, `err`=1 and `slot_rst_rel`=0, and writes nothing more. `err` holds until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_on | input | 1 | Power-on request, sampled while idle |
| cmd_off | input | 1 | Power-off request, sampled while idle |
| card_present | input | 1 | High while a card is inserted |
| pwr_rd | input | 2 | Current slot power-state code |
| pwr_wr_en | output | 1 | One-cycle write strobe for the power-state field |
| pwr_wr_code | output | 2 | Code to write, valid with `pwr_wr_en` |
| slot_rst_rel | output | 1 | High releases the card reset line |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command strobe |
| err | output | 1 | Last command aborted on card removal |

## Verification
The bench builds the sequencer with waits of 3, 5, 4 and 6 cycles. Its register model takes 4 cycles to move from code 3 to 0. With these values every timed step of power-up, the wait for switch-off and each abort window lands at an exact, small cycle number. The bench can therefore compare each write, each reset-release edge and each completion to the exact cycle. Its register model can also inject code 3 by itself, which exercises the drain wait in front of both command kinds.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

   typedef enum logic [1:0] {
      PWR_OFF   = 2'd0,
      PWR_PREP  = 2'd1,
      PWR_ON    = 2'd2,
      PWR_DRAIN = 2'd3
   } pwr_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAITQ,
      ST_PREP,
      ST_APPLY,
      ST_HOLD,
      ST_SETTLE,
      ST_FALL
   } seq_st_e;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/slot_pwr_timer.sv
module slot_pwr_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // Last cycle of a window of load_val cycles
   assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/slot_pwr_fsm.sv
module slot_pwr_fsm
   import slot_pwr_pkg::*;
#(
   parameter int unsigned CNT_W          = 8,
   parameter int unsigned DLY_PREP       = 4,
   parameter int unsigned DLY_APPLY      = 4,
   parameter int unsigned DLY_RELEASE    = 4,
   parameter int unsigned DLY_SETTLE     = 4,
   parameter bit          ABORT_ON_EJECT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_on,
   input  logic             cmd_off,
   input  logic             card_present,
   input  logic [1:0]       pwr_rd,
   input  logic             tmr_expire,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             pwr_wr_en,
   output logic [1:0]       pwr_wr_code,
   output logic             slot_rst_rel,
   output logic             busy,
   output logic             done,
   output logic             err
);

   seq_st_e   st_q, st_n;
   logic      op_on_q;
   logic      card_lost;
   logic      fin, fin_err, wr_go, rel_set, rel_clr;
   pwr_code_e wr_val;

   generate
      if (ABORT_ON_EJECT) begin : g_abort
         assign card_lost = ~card_present;
      end else begin : g_no_abort
         logic unused_card;
         assign unused_card = card_present;
         assign card_lost   = 1'b0;
      end
   endgenerate

   always_comb begin
      st_n     = st_q;
      fin      = 1'b0;
      fin_err  = 1'b0;
      wr_go    = 1'b0;
      wr_val   = PWR_OFF;
      rel_set  = 1'b0;
      rel_clr  = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (cmd_on || cmd_off) st_n = ST_WAITQ;
         end
         ST_WAITQ: begin
            if (op_on_q && card_lost) begin
               fin     = 1'b1;
               fin_err = 1'b1;
               rel_clr = 1'b1;
            end else if (pwr_rd != PWR_DRAIN) begin
               if (op_on_q) begin
                  if (pwr_rd != PWR_OFF) begin
                     fin = 1'b1;
                  end else begin
                     tmr_load = 1'b1;
                     tmr_val  = CNT_W'(DLY_PREP);
                     st_n     = ST_PREP;
                  end
               end else if (pwr_rd != PWR_ON) begin
                  fin = 1'b1;
               end else begin
                  wr_go   = 1'b1;
                  wr_val  = PWR_DRAIN;
                  rel_clr = 1'b1;
                  st_n    = ST_FALL;
               end
            end
         end
         ST_PREP: begin
            if (card_lost) begin
               fin = 1'b1; fin_err = 1'b1; rel_clr = 1'b1;
            end else if (tmr_expire) begin
               wr_go    = 1'b1;
               wr_val   = PWR_PREP;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(DLY_APPLY);
               st_n     = ST_APPLY;
            end
         end
         ST_APPLY: begin
            if (card_lost) begin
               fin = 1'b1; fin_err = 1'b1; rel_clr = 1'b1;
            end else if (tmr_expire) begin
               wr_go    = 1'b1;
               wr_val   = PWR_ON;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(DLY_RELEASE);
               st_n     = ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (card_lost) begin
               fin = 1'b1; fin_err = 1'b1; rel_clr = 1'b1;
            end else if (tmr_expire) begin
               rel_set  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(DLY_SETTLE);
               st_n     = ST_SETTLE;
            end
         end
         ST_SETTLE: begin
            if (card_lost) begin
               fin = 1'b1; fin_err = 1'b1; rel_clr = 1'b1;
            end else if (tmr_expire) begin
               fin = 1'b1;
            end
         end
         ST_FALL: begin
            if (pwr_rd == PWR_OFF) fin = 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase
      if (fin) st_n = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         op_on_q      <= 1'b0;
         busy         <= 1'b0;
         done         <= 1'b0;
         err          <= 1'b0;
         pwr_wr_en    <= 1'b0;
         pwr_wr_code  <= PWR_OFF;
         slot_rst_rel <= 1'b0;
      end else begin
         st_q      <= st_n;
         done      <= fin;
         pwr_wr_en <= wr_go;
         if (wr_go) pwr_wr_code <= wr_val;
         if (st_q == ST_IDLE && (cmd_on || cmd_off)) begin
            op_on_q <= cmd_on;
            busy    <= 1'b1;
            err     <= 1'b0;
         end
         if (fin) begin
            busy <= 1'b0;
            err  <= fin_err;
         end
         if (rel_clr)      slot_rst_rel <= 1'b0;
         else if (rel_set) slot_rst_rel <= 1'b1;
      end
   end

endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
   import slot_pwr_pkg::*;
#(
   parameter int unsigned DLY_PREP       = 125000,
   parameter int unsigned DLY_APPLY      = 1250000,
   parameter int unsigned DLY_RELEASE    = 3375000,
   parameter int unsigned DLY_SETTLE     = 15000000,
   parameter bit          ABORT_ON_EJECT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_on,
   input  logic       cmd_off,
   input  logic       card_present,
   input  logic [1:0] pwr_rd,
   output logic       pwr_wr_en,
   output logic [1:0] pwr_wr_code,
   output logic       slot_rst_rel,
   output logic       busy,
   output logic       done,
   output logic       err
);

   localparam int unsigned DLY_MAX = max_of4(DLY_PREP, DLY_APPLY, DLY_RELEASE, DLY_SETTLE);
   localparam int unsigned CNT_W   = (DLY_MAX < 2) ? 1 : $clog2(DLY_MAX + 1);

   generate
      if (DLY_PREP < 1 || DLY_APPLY < 1 || DLY_RELEASE < 1 || DLY_SETTLE < 1) begin : g_bad_delay
         $error("slot_pwr_seq: every delay must be at least one cycle");
      end
      if (CNT_W > 32) begin : g_bad_width
         $error("slot_pwr_seq: delay counter wider than 32 bits");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expire;

   slot_pwr_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   slot_pwr_fsm #(
      .CNT_W          (CNT_W),
      .DLY_PREP       (DLY_PREP),
      .DLY_APPLY      (DLY_APPLY),
      .DLY_RELEASE    (DLY_RELEASE),
      .DLY_SETTLE     (DLY_SETTLE),
      .ABORT_ON_EJECT (ABORT_ON_EJECT)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_on       (cmd_on),
      .cmd_off      (cmd_off),
      .card_present (card_present),
      .pwr_rd       (pwr_rd),
      .tmr_expire   (tmr_expire),
      .tmr_load     (tmr_load),
      .tmr_val      (tmr_val),
      .pwr_wr_en    (pwr_wr_en),
      .pwr_wr_code  (pwr_wr_code),
      .slot_rst_rel (slot_rst_rel),
      .busy         (busy),
      .done         (done),
      .err          (err)
   );

endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_on,
   input logic       cmd_off,
   input logic       card_present,
   input logic [1:0] pwr_rd,
   input logic       pwr_wr_en,
   input logic [1:0] pwr_wr_code,
   input logic       slot_rst_rel,
   input logic       busy,
   input logic       done,
   input logic       err
);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_falls_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (cmd_on || cmd_off)) |=> (busy && !err));

   assert_write_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_wr_en |-> (busy && pwr_wr_code != 2'd0));

   assert_off_write_from_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_wr_en && pwr_wr_code == 2'd3) |-> ($past(pwr_rd) == 2'd2 && !slot_rst_rel));

   assert_prep_not_during_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_wr_en && pwr_wr_code == 2'd1) |-> $past(pwr_rd) != 2'd3);

   assert_release_needs_card_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_rst_rel) |-> $past(card_present));

   assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

endmodule

bind slot_pwr_seq slot_pwr_seq_chk u_chk (.*);

// File: tb/slot_pwr_seq_tb.sv
`timescale 1ns/1ps
module slot_pwr_seq_tb;

   localparam int P = 3;
   localparam int O = 5;
   localparam int R = 4;
   localparam int S = 6;
   localparam int L = 4;
   localparam int EV_WR   = 0;
   localparam int EV_REL  = 1;
   localparam int EV_DONE = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_on = 1'b0, cmd_off = 1'b0, card = 1'b1;
   logic [1:0] reg_q;
   logic       wr_en, rel, busy, done, err;
   logic [1:0] wr_code;
   logic       inj_req = 1'b0;
   logic [1:0] inj_val = 2'd0;
   int         decay;
   int         cyc = 0;
   int         checks = 0, fails = 0;
   bit         finished = 1'b0;

   typedef struct {int kind; int val; int at; string req;} ev_t;
   ev_t q[$];

   always #4 clk = ~clk;

   slot_pwr_seq #(
      .DLY_PREP (P), .DLY_APPLY (O), .DLY_RELEASE (R), .DLY_SETTLE (S), .ABORT_ON_EJECT (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .cmd_on (cmd_on), .cmd_off (cmd_off),
      .card_present (card), .pwr_rd (reg_q), .pwr_wr_en (wr_en), .pwr_wr_code (wr_code),
      .slot_rst_rel (rel), .busy (busy), .done (done), .err (err)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // Power-state field model: code 3 decays to 0, removal forces 0
   always @(posedge clk) begin
      if (!rst_n) begin
         reg_q <= 2'd0; decay <= 0;
      end else if (!card) begin
         reg_q <= 2'd0; decay <= 0;
      end else if (inj_req) begin
         reg_q <= inj_val; decay <= (inj_val == 2'd3) ? L : 0;
      end else if (wr_en) begin
         reg_q <= wr_code; decay <= (wr_code == 2'd3) ? L : 0;
      end else if (decay == 1) begin
         reg_q <= 2'd0; decay <= 0;
      end else if (decay > 1) begin
         decay <= decay - 1;
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push(int k, int v, int t, string req);
      ev_t e;
      e.kind = k; e.val = v; e.at = t; e.req = req;
      q.push_back(e);
   endtask

   task automatic see(int k, int v);
      ev_t e;
      if (q.size() == 0) begin
         check(1'b0, "R9", "unexpected event kind", k, -1);
      end else begin
         e = q.pop_front();
         check(e.kind == k && e.val == v && e.at == cyc, e.req,
               $sformatf("event kind %0d/%0d val %0d/%0d cycle", k, e.kind, v, e.val), cyc, e.at);
      end
   endtask

   // Monitor
   logic rel_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) see(EV_WR, int'(wr_code));
         if (rel != rel_prev) see(EV_REL, int'(rel));
         rel_prev = rel;
         if (done) begin
            see(EV_DONE, int'(err));
            check(busy == 1'b0, "R8", "busy during done", int'(busy), 0);
         end
      end
   end

   task automatic send(bit on, bit off, bit inj, logic [1:0] iv, output int a);
      @(negedge clk);
      cmd_on = on; cmd_off = off; inj_req = inj; inj_val = iv;
      @(negedge clk);
      cmd_on = 1'b0; cmd_off = 1'b0; inj_req = 1'b0;
      a = cyc;
   endtask

   task automatic wait_to(int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic drain();
      do @(negedge clk); while (q.size() != 0 || busy);
      repeat (2) @(negedge clk);
   endtask

   task automatic push_on(int d, string rq);
      push(EV_WR,   1, d + P,             rq);
      push(EV_WR,   2, d + P + O,         "R4");
      push(EV_REL,  1, d + P + O + R,     "R5");
      push(EV_DONE, 0, d + P + O + R + S, "R5");
   endtask

   task automatic push_off(int a);
      push(EV_WR,   3, a + 1,     "R7");
      push(EV_REL,  0, a + 1,     "R7");
      push(EV_DONE, 0, a + L + 3, "R7");
   endtask

   initial begin
      int a, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(busy == 0, "R1", "busy", int'(busy), 0);
      check(done == 0, "R1", "done", int'(done), 0);
      check(err == 0,  "R1", "err", int'(err), 0);
      check(wr_en == 0, "R1", "wr_en", int'(wr_en), 0);
      check(rel == 0,  "R1", "rst_rel", int'(rel), 0);

      // R4 R5: full power-on from off
      send(1, 0, 0, 2'd0, a);
      push_on(a + 1, "R4");
      wait_to(a + 2);
      check(busy == 1, "R8", "busy mid sequence", int'(busy), 1);
      drain();

      // R3: power-on while already on
      send(1, 0, 0, 2'd0, a);
      push(EV_DONE, 0, a + 1, "R3");
      drain();

      // R9: both commands at once, power-on wins (state 2 -> immediate end)
      send(1, 1, 0, 2'd0, a);
      push(EV_DONE, 0, a + 1, "R9");
      drain();
      check(reg_q == 2'd2, "R9", "power state after dual command", int'(reg_q), 2);

      // R7: power-off from on
      send(0, 1, 0, 2'd0, a);
      push_off(a);
      drain();

      // R6: power-off while already off
      send(0, 1, 0, 2'd0, a);
      push(EV_DONE, 0, a + 1, "R6");
      drain();

      // R2: power-on waits out an in-flight switch-off
      send(1, 0, 1, 2'd3, a);
      push_on(a + L + 1, "R2");
      drain();
      send(0, 1, 0, 2'd0, a);
      push_off(a);
      drain();

      // R9: power-off request while busy is ignored
      send(1, 0, 0, 2'd0, a);
      push_on(a + 1, "R4");
      wait_to(a + 2);
      cmd_off = 1'b1;
      @(negedge clk);
      cmd_off = 1'b0;
      check(busy == 1, "R9", "busy after ignored command", int'(busy), 1);
      drain();
      check(reg_q == 2'd2, "R9", "power state after ignored off", int'(reg_q), 2);
      send(0, 1, 0, 2'd0, a);
      push_off(a);
      drain();

      // R10: card removed during power-on
      send(1, 0, 0, 2'd0, a);
      push(EV_WR, 1, a + 1 + P, "R4");
      wait_to(a + 1 + P + 2);
      card = 1'b0;
      c = cyc;
      push(EV_DONE, 1, c + 1, "R10");
      drain();
      check(err == 1, "R10", "err held", int'(err), 1);
      check(rel == 0, "R10", "rst_rel after abort", int'(rel), 0);
      card = 1'b1;
      repeat (P + O + 4) @(negedge clk);
      check(wr_en == 0 && q.size() == 0, "R10", "no writes after abort", int'(wr_en), 0);

      // R2: power-off waits out drain, then finds off; err cleared on accept (R10)
      send(0, 1, 1, 2'd3, a);
      check(err == 0, "R10", "err cleared on accept", int'(err), 0);
      push(EV_DONE, 0, a + L + 1, "R2");
      drain();

      check(q.size() == 0, "R8", "pending expected events", q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule